// File: doc/BRIEF.md
# Ternary-Weight Sparse Matrix-Vector Engine

This engine multiplies a fixed-size matrix of ternary weights by an activation vector without a single multiplier. Every weight is a 2-bit code that tells its lane to add the activation, subtract it, or leave the accumulator alone. A row is split into blocks of `LANES` weights. Each block is fetched as one word over a request/data handshake and applied by `LANES` parallel add/subtract lanes, and successive rows reuse the same lanes in time. When a row is finished, a balanced adder tree folds the lane sums into one saturated result, which streams out with the row index.

A job begins with a one-cycle `start` pulse that carries a per-block zero bitmap. A block marked in that bitmap is never requested and never computed. Activations sit in a two-bank on-chip buffer. `start` hands the bank that was just loaded to the datapath, and writes that arrive during the job fill the other bank for the next vector.

The controller is a six-state machine. `ST_IDLE` waits for `start` (IDLE→SCAN). `ST_SCAN` looks up the zero flag of the current block: a flagged block advances the block index and stays in SCAN, or goes to REDUCE after the last block of the row; an unflagged block goes to REQ. `ST_REQ` holds the request until it is accepted (REQ→DATA). `ST_DATA` waits for the weight word, then applies it (DATA→SCAN, or DATA→REDUCE on the last block). `ST_REDUCE` registers the clamped tree sum (REDUCE→EMIT). `ST_EMIT` presents the result for one cycle and clears the lanes (EMIT→SCAN for the next row, EMIT→IDLE after the last row).

Top module: `tern_mv_engine`

## Requirements
- R1: Weight code 2'b01 means +1, 2'b11 means -1, and 2'b00 and the reserved 2'b10 both mean 0; bits [2j+1:2j] of a weight word belong to lane j, which covers column blk*LANES+j of the row.
- R2: Each row result equals the sum over all columns of weight times activation, where activations are signed 8-bit.
- R3: Each lane accumulator saturates at the signed ACC_W-bit limits after every update, and the sum of the lane values is clamped to the same limits.
- R4: A block whose zero-map bit (bit row*BPR+blk) is set is never requested and adds nothing to its row, whatever its stored weights hold.
- R5: Unflagged blocks are requested in ascending address order, with address row*BPR+blk, and req_valid stays high with a stable address until req_ready is seen.
- R6: A weight word is consumed only in a cycle where wdat_valid and wdat_ready are both high; stalls on either handshake do not change any result.
- R7: `start` switches the datapath to the bank that was just loaded; activation writes made during a job go to the other bank and do not affect the job in progress.
- R8: Every job emits exactly ROWS results, one res_valid cycle each, in ascending res_row order, with res_last high only on row ROWS-1.
- R9: After reset the engine is idle: busy, req_valid, wdat_ready and res_valid are low.
- R10: A `start` pulse while busy is ignored: neither the zero map nor the bank selection changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job; swaps activation banks |
| zero_map | input | ROWS*COLS/LANES | Per-block zero flags, captured at start |
| act_wr_en | input | 1 | Activation write strobe (load bank) |
| act_wr_idx | input | log2(COLS) | Activation column index |
| act_wr_data | input | ACT_W | Signed activation value |
| req_valid | output | 1 | Weight block fetch request |
| req_ready | input | 1 | Fetch request accepted |
| req_addr | output | log2(ROWS*COLS/LANES) | Block address row*BPR+blk |
| wdat_valid | input | 1 | Weight word valid |
| wdat_ready | output | 1 | Engine waiting for a weight word |
| wdat | input | 2*LANES | Packed 2-bit weight codes |
| res_valid | output | 1 | Row result strobe |
| res_data | output | ACC_W | Saturated signed row result |
| res_row | output | log2(ROWS) | Row index of the result |
| res_last | output | 1 | Result belongs to the final row |
| busy | output | 1 | Job in progress |

## Verification
Random ternary matrices are run with zero-block densities of 0%, 10%, 25%, 40%, 50%, 75%, 90% and 100%, and every run is compared with a behavioural product. The dense end exercises every fetch and all four codes, including the reserved one. The sparse end shows whether flagged blocks are really skipped: their stored words are nonzero, so a wrongly fetched or computed block changes the sum, and the request count is compared with the number of unflagged blocks. Runs with random stalls on both handshakes, new activations written during a job, and a `start` pulse in mid-job separate a correct handshake and bank discipline from a design that happens to work only under ideal timing. A narrow-accumulator case with crafted rows separates lane-level saturation from clamping only the final sum.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REQ,
        ST_DATA,
        ST_REDUCE,
        ST_EMIT
    } eng_state_t;

    typedef enum logic [1:0] {
        OP_SKIP,
        OP_ADD,
        OP_SUB
    } lane_op_t;

    localparam logic [1:0] WC_ZERO = 2'b00;
    localparam logic [1:0] WC_POS  = 2'b01;
    localparam logic [1:0] WC_RSV  = 2'b10;
    localparam logic [1:0] WC_NEG  = 2'b11;

    // Reserved code decodes as zero (R1)
    function automatic lane_op_t decode_w(input logic [1:0] code);
        case (code)
            WC_POS:  return OP_ADD;
            WC_NEG:  return OP_SUB;
            default: return OP_SKIP;
        endcase
    endfunction

endpackage

// File: rtl/tern_act_buf.sv
module tern_act_buf #(
    parameter int LANES = 8,
    parameter int ACT_W = 8,
    parameter int COLS  = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [$clog2(COLS)-1:0]  wr_idx,
    input  logic [ACT_W-1:0]         wr_data,
    input  logic                     rd_bank,
    input  logic [$clog2(COLS/LANES)-1:0] rd_blk,
    output logic [LANES*ACT_W-1:0]   rd_data
);
    localparam int LW = $clog2(LANES);

    logic [ACT_W-1:0] mem [2][COLS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_bank][wr_idx] <= wr_data;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rd_data[g*ACT_W +: ACT_W] = mem[rd_bank][{rd_blk, LW'(g)}];
    end

endmodule

// File: rtl/tern_lane_array.sv
module tern_lane_array
    import tern_pkg::*;
#(
    parameter int LANES = 8,
    parameter int ACT_W = 8,
    parameter int ACC_W = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   en,
    input  logic [LANES*ACT_W-1:0] acts,
    input  logic [2*LANES-1:0]     wts,
    output logic [LANES*ACC_W-1:0] sums
);
    localparam logic signed [ACC_W:0] HI = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] LO = {2'b11, {(ACC_W-1){1'b0}}};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W:0]   ext, cur, nxt;
        logic signed [ACC_W-1:0] sat;

        assign ext = {{(ACC_W+1-ACT_W){acts[g*ACT_W+ACT_W-1]}}, acts[g*ACT_W +: ACT_W]};
        assign cur = {acc[ACC_W-1], acc};

        always_comb begin
            unique case (decode_w(wts[2*g +: 2]))
                OP_ADD:  nxt = cur + ext;
                OP_SUB:  nxt = cur - ext;
                default: nxt = cur;
            endcase
            if (nxt > HI)      sat = HI[ACC_W-1:0];
            else if (nxt < LO) sat = LO[ACC_W-1:0];
            else               sat = nxt[ACC_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n || clr) acc <= '0;
            else if (en)       acc <= sat;
        end

        assign sums[g*ACC_W +: ACC_W] = acc;
    end

endmodule

// File: rtl/tern_reduce.sv
module tern_reduce #(
    parameter int LANES = 8,
    parameter int ACC_W = 20
) (
    input  logic [LANES*ACC_W-1:0] sums,
    output logic [ACC_W-1:0]       total
);
    localparam int SW = ACC_W + $clog2(LANES);
    localparam logic signed [SW-1:0] HI = {{(SW-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SW-1:0] LO = {{(SW-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

    // Heap-ordered balanced tree: leaves at LANES-1 .. 2*LANES-2, root at 0
    logic signed [SW-1:0] node [2*LANES-1];

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            node[LANES-1+k] = {{(SW-ACC_W){sums[k*ACC_W+ACC_W-1]}}, sums[k*ACC_W +: ACC_W]};
        end
        for (int k = LANES-2; k >= 0; k--) begin
            node[k] = node[2*k+1] + node[2*k+2];
        end
        if (node[0] > HI)      total = HI[ACC_W-1:0];
        else if (node[0] < LO) total = LO[ACC_W-1:0];
        else                   total = node[0][ACC_W-1:0];
    end

endmodule

// File: rtl/tern_mv_engine.sv
module tern_mv_engine
    import tern_pkg::*;
#(
    parameter int LANES = 8,
    parameter int ACT_W = 8,
    parameter int ACC_W = 20,
    parameter int ROWS  = 4,
    parameter int COLS  = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [ROWS*(COLS/LANES)-1:0]         zero_map,
    input  logic                                 act_wr_en,
    input  logic [$clog2(COLS)-1:0]              act_wr_idx,
    input  logic [ACT_W-1:0]                     act_wr_data,
    output logic                                 req_valid,
    input  logic                                 req_ready,
    output logic [$clog2(ROWS*(COLS/LANES))-1:0] req_addr,
    input  logic                                 wdat_valid,
    output logic                                 wdat_ready,
    input  logic [2*LANES-1:0]                   wdat,
    output logic                                 res_valid,
    output logic [ACC_W-1:0]                     res_data,
    output logic [$clog2(ROWS)-1:0]              res_row,
    output logic                                 res_last,
    output logic                                 busy
);
    localparam int BPR  = COLS / LANES;
    localparam int NBLK = ROWS * BPR;
    localparam int BW   = $clog2(BPR);
    localparam int RW   = $clog2(ROWS);

    eng_state_t st, nxt;
    logic [RW-1:0]    row;
    logic [BW-1:0]    blk;
    logic [NBLK-1:0]  zmap_q;
    logic             cb;
    logic [ACC_W-1:0] res_q;

    logic [RW+BW-1:0] cur_addr;
    logic             flag, last_blk, last_row;
    logic [LANES*ACT_W-1:0] acts;
    logic [LANES*ACC_W-1:0] sums;
    logic [ACC_W-1:0]       total;
    logic                   lane_en, lane_clr;

    assign cur_addr = {row, blk};
    assign flag     = zmap_q[cur_addr];
    assign last_blk = (blk == BW'(BPR-1));
    assign last_row = (row == RW'(ROWS-1));

    tern_act_buf #(.LANES(LANES), .ACT_W(ACT_W), .COLS(COLS)) u_buf (
        .clk(clk), .wr_en(act_wr_en), .wr_bank(~cb), .wr_idx(act_wr_idx),
        .wr_data(act_wr_data), .rd_bank(cb), .rd_blk(blk), .rd_data(acts)
    );

    tern_lane_array #(.LANES(LANES), .ACT_W(ACT_W), .ACC_W(ACC_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .clr(lane_clr), .en(lane_en),
        .acts(acts), .wts(wdat), .sums(sums)
    );

    tern_reduce #(.LANES(LANES), .ACC_W(ACC_W)) u_tree (
        .sums(sums), .total(total)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (start) nxt = ST_SCAN;
            ST_SCAN:   if (!flag)     nxt = ST_REQ;
                       else if (last_blk) nxt = ST_REDUCE;
            ST_REQ:    if (req_ready) nxt = ST_DATA;
            ST_DATA:   if (wdat_valid) nxt = last_blk ? ST_REDUCE : ST_SCAN;
            ST_REDUCE: nxt = ST_EMIT;
            ST_EMIT:   nxt = last_row ? ST_IDLE : ST_SCAN;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_valid  = 1'b0;
        wdat_ready = 1'b0;
        res_valid  = 1'b0;
        lane_en    = 1'b0;
        lane_clr   = 1'b0;
        unique case (st)
            ST_IDLE:   lane_clr = 1'b1;
            ST_SCAN:   ;
            ST_REQ:    req_valid = 1'b1;
            ST_DATA:   begin wdat_ready = 1'b1; lane_en = wdat_valid; end
            ST_REDUCE: ;
            ST_EMIT:   begin res_valid = 1'b1; lane_clr = 1'b1; end
            default:   ;
        endcase
    end

    assign busy     = (st != ST_IDLE);
    assign req_addr = cur_addr;
    assign res_data = res_q;
    assign res_row  = row;
    assign res_last = res_valid && last_row;

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row    <= '0;
            blk    <= '0;
            zmap_q <= '0;
            cb     <= 1'b0;
            res_q  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    zmap_q <= zero_map;
                    cb     <= ~cb;
                    row    <= '0;
                    blk    <= '0;
                end
                ST_SCAN: if (flag && !last_blk) blk <= blk + 1'b1;
                ST_DATA: if (wdat_valid && !last_blk) blk <= blk + 1'b1;
                ST_REDUCE: res_q <= total;
                ST_EMIT: begin
                    blk <= '0;
                    row <= row + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Assertions
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    assert_no_flagged_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !zmap_q[req_addr]);

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_last_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_last |-> res_row == RW'(ROWS-1));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> cb == $past(cb) && zmap_q == $past(zmap_q));

    assert_idle_after_reset_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> !busy && !res_valid && !req_valid);

endmodule

// File: tb/tb_tern_mv_engine.sv
module tb_tern_mv_engine;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LANES = 8;
    localparam int AW    = 10;
    localparam int ROWS  = 4;
    localparam int COLS  = 32;
    localparam int BPR   = COLS / LANES;
    localparam int NBLK  = ROWS * BPR;
    localparam int NT    = 8;

    // Stimulus table: seed, zero-block percentage, stall mode
    localparam int unsigned T_SEED [NT] = '{32'h1234_5678, 32'h0bad_cafe, 32'h7777_1111, 32'h2468_ace0,
                                            32'h1357_9bdf, 32'hdead_0042, 32'h0f0f_3c3c, 32'h5a5a_a5a5};
    localparam int T_PCT   [NT] = '{0, 10, 25, 40, 50, 75, 90, 100};
    localparam bit T_STALL [NT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NBLK-1:0] zero_map = '0;
    logic act_wr_en = 1'b0;
    logic [4:0] act_wr_idx = '0;
    logic [7:0] act_wr_data = '0;
    logic req_valid, wdat_ready, res_valid, res_last, busy;
    logic req_ready = 1'b1;
    logic [3:0] req_addr;
    logic wv = 1'b0;
    logic [15:0] wd = '0;
    logic [AW-1:0] res_data;
    logic [1:0] res_row;

    always #4 clk = ~clk;

    tern_mv_engine #(.LANES(LANES), .ACT_W(8), .ACC_W(AW), .ROWS(ROWS), .COLS(COLS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .zero_map(zero_map),
        .act_wr_en(act_wr_en), .act_wr_idx(act_wr_idx), .act_wr_data(act_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .wdat_valid(wv), .wdat_ready(wdat_ready), .wdat(wd),
        .res_valid(res_valid), .res_data(res_data), .res_row(res_row),
        .res_last(res_last), .busy(busy)
    );

    int checks = 0, errors = 0;
    logic [1:0] wcode [ROWS][COLS];
    bit zf [NBLK];
    int act_job [COLS];
    int act_nx  [COLS];
    int unsigned rs;
    bit stall_mode = 1'b0;
    logic [15:0] lf = 16'hace1;

    // Counters written only by their own process
    int req_total = 0, bad_flag_total = 0, bad_order_total = 0, last_a = -1;
    int res_total = 0, last_total = 0, order_err_total = 0;
    int got [ROWS];
    bit pend = 1'b0;

    task automatic chk(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic rnd(output int unsigned v);
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        v = rs;
    endtask

    function automatic logic [15:0] blk_word(input int a);
        logic [15:0] w;
        int r, b;
        r = a / BPR;
        b = a % BPR;
        if (zf[a]) return 16'h5555;          // skipped block holds nonzero weights (R4)
        for (int j = 0; j < LANES; j++) w[2*j +: 2] = wcode[r][b*LANES+j];
        return w;
    endfunction

    function automatic int sat(input int v);
        int hi, lo;
        hi = (1 << (AW-1)) - 1;
        lo = -(1 << (AW-1));
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic int wval(input logic [1:0] c);
        return (c == 2'b01) ? 1 : ((c == 2'b11) ? -1 : 0);
    endfunction

    function automatic int expect_row(input int r);
        int tot, acc;
        tot = 0;
        for (int j = 0; j < LANES; j++) begin
            acc = 0;
            for (int b = 0; b < BPR; b++)
                if (!zf[r*BPR+b]) acc = sat(acc + wval(wcode[r][b*LANES+j]) * act_job[b*LANES+j]);
            tot += acc;
        end
        return sat(tot);
    endfunction

    // Handshake partner for the weight fetch
    always @(posedge clk) begin
        lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        req_ready <= stall_mode ? lf[0] : 1'b1;
        if (!busy) last_a <= -1;
        if (req_valid && req_ready) begin
            req_total <= req_total + 1;
            if (zf[req_addr]) bad_flag_total <= bad_flag_total + 1;
            if (int'(req_addr) <= last_a) bad_order_total <= bad_order_total + 1;
            last_a <= int'(req_addr);
            wd   <= blk_word(int'(req_addr));
            pend <= 1'b1;
        end else if (pend && (!stall_mode || lf[1])) begin
            wv   <= 1'b1;
            pend <= 1'b0;
        end else if (wv && wdat_ready) begin
            wv <= 1'b0;
            wd <= 16'hffff;
        end
    end

    // Result monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            got[res_row] = $signed(res_data);
            if (int'(res_row) != res_total % ROWS) order_err_total++;
            res_total++;
            if (res_last) last_total++;
        end
    end

    task automatic write_act(input int c, input int v);
        act_wr_en   = 1'b1;
        act_wr_idx  = 5'(c);
        act_wr_data = 8'(v);
    endtask

    task automatic load_now(input int v [COLS]);
        for (int c = 0; c < COLS; c++) begin
            @(negedge clk);
            write_act(c, v[c]);
        end
        @(negedge clk);
        act_wr_en = 1'b0;
    endtask

    task automatic run_job(input bit stall, input bit restart, input bit load_next);
        int r0, l0, q0, b0, o0, e0, c, cyc, nreq;
        stall_mode = stall;
        r0 = res_total; l0 = last_total; q0 = req_total;
        b0 = bad_flag_total; o0 = bad_order_total; e0 = order_err_total;
        for (int a = 0; a < NBLK; a++) zero_map[a] = zf[a];
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        c = 0; cyc = 0;
        while (busy && cyc < 5000) begin
            if (load_next && c < COLS) begin write_act(c, act_nx[c]); c++; end
            else act_wr_en = 1'b0;
            if (restart && cyc == 6) begin start = 1'b1; zero_map = ~zero_map; end
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        act_wr_en = 1'b0;
        chk(cyc < 5000, "R8 job completes (watchdog)", cyc, 5000);
        while (load_next && c < COLS) begin
            write_act(c, act_nx[c]); c++;
            @(negedge clk);
        end
        act_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        nreq = 0;
        for (int a = 0; a < NBLK; a++) if (!zf[a]) nreq++;
        chk(res_total - r0 == ROWS, "R8 result count", res_total - r0, ROWS);
        chk(last_total - l0 == 1, "R8 single last flag", last_total - l0, 1);
        chk(order_err_total == e0, "R8 row order", order_err_total - e0, 0);
        chk(req_total - q0 == nreq, "R4 R5 request count", req_total - q0, nreq);
        chk(bad_flag_total == b0, "R4 no flagged request", bad_flag_total - b0, 0);
        chk(bad_order_total == o0, "R5 ascending addresses", bad_order_total - o0, 0);
        for (int r = 0; r < ROWS; r++)
            chk(got[r] == expect_row(r), "R1 R2 R3 R6 R7 R10 row value", got[r], expect_row(r));
    endtask

    // Watchdog
    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned v;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(!busy, "R9 busy low", busy, 0);
        chk(!res_valid, "R9 res_valid low", res_valid, 0);
        chk(!req_valid, "R9 req_valid low", req_valid, 0);
        chk(!wdat_ready, "R9 wdat_ready low", wdat_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !req_valid, "R9 idle after release", busy, 0);

        rs = 32'h9e37_79b9;
        for (int c = 0; c < COLS; c++) begin rnd(v); act_job[c] = int'(v % 256) - 128; end
        load_now(act_job);

        // Table walk: density sweep, stalls, next-vector loading (R7), restart (R10)
        for (int t = 0; t < NT; t++) begin
            rs = T_SEED[t];
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) begin rnd(v); wcode[r][c] = v[5:4]; end
            for (int a = 0; a < NBLK; a++) begin rnd(v); zf[a] = (int'(v % 100) < T_PCT[t]); end
            for (int c = 0; c < COLS; c++) begin rnd(v); act_nx[c] = int'(v % 256) - 128; end
            run_job(T_STALL[t], t == 3, 1'b1);
            act_job = act_nx;
        end

        // R3: lane saturation versus final clamp, with row 3 fully flagged (R4)
        for (int c = 0; c < COLS; c++) begin
            int j, b;
            j = c % LANES;
            b = c / LANES;
            act_job[c] = (j == 0) ? -128 : ((j == 1) ? ((b == 3) ? -127 : -128) : 127);
            wcode[0][c] = (j == 0) ? 2'b11 : ((j == 1) ? 2'b01 : 2'b00);
            wcode[1][c] = 2'b01;
            wcode[2][c] = 2'b11;
            wcode[3][c] = 2'b01;
        end
        for (int a = 0; a < NBLK; a++) zf[a] = (a >= 3*BPR);
        load_now(act_job);
        run_job(1'b0, 1'b0, 1'b0);
        chk(got[0] == 0, "R3 lane saturates before sum", got[0], 0);
        chk(got[1] == 511, "R3 positive clamp", got[1], 511);
        chk(got[2] == -512, "R3 negative clamp", got[2], -512);
        chk(got[3] == 0, "R4 flagged row is zero", got[3], 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule